// File: doc/BRIEF.md
# Fully Associative Micro Translation Cache

This block is a small fully associative cache of address translations that sits in front of a larger, low-associativity joint translation array. A lookup presents a virtual page number together with an address-space identifier. If a valid entry holds both, the physical frame number and the permission bits come back combinationally in the same cycle. If none does, the block reports a miss, latches the missed tag and raises a refill request towards the joint array. It then waits for the translation to come back, stores it in a victim slot and lowers the request.

Writes into the joint array have no effect on the entries held here. A translation evicted from the two-way main array therefore stays usable in this cache until software pulses the single bulk-invalidate input. The eight-entry default suits the data side. Setting `ENTRIES` to 4 gives the instruction-side variant.

Permissions are stored as two separate three-bit groups, one for kernel mode and one for user mode. Within each group bit 2 is read, bit 1 is write and bit 0 is execute. The block does not interpret these bits.

Top module: `utlb_top`

## Requirements
- R1: While no refill is pending, a lookup whose page number and identifier both equal those of a valid entry asserts `lk_hit` in the same cycle. It returns that entry's frame number and both permission groups, and `lk_miss` stays low.
- R2: A lookup that matches a valid entry's page number but carries a different identifier, or that matches no valid entry, asserts `lk_miss` and leaves `lk_hit` low.
- R3: A miss taken while no refill is pending, and without `inv_all` in the same cycle, raises `rf_req` from the next cycle. `rf_vpn` and `rf_asid` carry the missed tag. All three hold steady until `rf_valid` or `inv_all` arrives.
- R4: While `rf_req` is high, every lookup reports a miss, even one that would otherwise hit, and the latched refill tag does not change.
- R5: `rf_valid` while `rf_req` is high stores the returned frame and permissions under the latched tag. `rf_req` is low in the next cycle, and a lookup of that tag then hits. `rf_valid` while no refill is pending has no effect.
- R6: A refill goes into the lowest-numbered invalid entry whenever at least one entry is invalid.
- R7: When all entries are valid, the victim comes from a binary tree pseudo-LRU with one bit per internal node. Node 0 is the root, and the children of node n are 2n+1 and 2n+2. A bit of 0 sends the victim search to the lower-index half and 1 to the upper half. Every hit and every fill sets each bit on the accessed entry's path to point away from that entry. The tree resets to all zeros and `inv_all` leaves it unchanged.
- R8: Filling one entry never clears any other entry. Entries leave only by being chosen as the victim or by `inv_all`.
- R9: `inv_all` clears every entry at the next edge and cancels a pending refill, so `rf_req` is low in the next cycle. A miss in the same cycle as `inv_all` starts no refill.
- R10: When `inv_all` and `rf_valid` arrive in the same cycle as a pending refill, the refilled translation is not left valid.
- R11: After reset no entry is valid, `rf_req` is low, and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_asid | input | ASID_W | Address-space identifier of the lookup |
| lk_hit | output | 1 | Lookup found a valid matching entry |
| lk_miss | output | 1 | Lookup found no usable entry |
| lk_pfn | output | PFN_W | Frame number of the hitting entry |
| lk_kperm | output | 3 | Kernel read/write/execute of the hitting entry |
| lk_uperm | output | 3 | User read/write/execute of the hitting entry |
| rf_req | output | 1 | Refill pending towards the joint array |
| rf_vpn | output | VPN_W | Page number being refilled |
| rf_asid | output | ASID_W | Identifier being refilled |
| rf_valid | input | 1 | Refill data present this cycle |
| rf_pfn | input | PFN_W | Refill frame number |
| rf_kperm | input | 3 | Refill kernel permissions |
| rf_uperm | input | 3 | Refill user permissions |
| inv_all | input | 1 | Bulk invalidate of every entry |

## Verification
A long pseudo-random walk runs over 24 tags: 12 page numbers under two identifiers, against eight entries. Each lookup is compared with a bench model of the entries and the replacement tree. A wrong victim choice, whether from the free-slot rule or from the tree, shows up as an unexpected hit or miss later on. Pairs of tags that share a page number but differ in identifier separate a full tag compare from a page-only compare.

Stall probes with tags known to be present, issued during a pending refill, separate a correct lookup stall from a hit that leaks through. Directed sequences cover the following cases and separate invalidate priority from fill priority:
- an invalidate while a refill is pending;
- an invalidate together with a miss;
- an invalidate together with refill data;
- refill data arriving with no refill pending.

// File: rtl/utlb_pkg.sv
package utlb_pkg;

  // Permission group: [2] read, [1] write, [0] execute
  typedef logic [2:0] perm_t;

  typedef enum logic {
    RF_IDLE = 1'b0,
    RF_WAIT = 1'b1
  } rf_state_e;

endpackage

// File: rtl/utlb_cam.sv
module utlb_cam
  import utlb_pkg::*;
#(
  parameter int N      = 8,
  parameter int VPN_W  = 19,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 19,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic [PFN_W-1:0]  wr_pfn_i,
  input  perm_t             wr_kperm_i,
  input  perm_t             wr_uperm_i,
  input  logic [VPN_W-1:0]  look_vpn_i,
  input  logic [ASID_W-1:0] look_asid_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  hit_idx_o,
  output logic [PFN_W-1:0]  hit_pfn_o,
  output perm_t             hit_kperm_o,
  output perm_t             hit_uperm_o,
  output logic [N-1:0]      valid_o
);

  logic [N-1:0]      valid_q;
  logic [N-1:0]      valid_d;
  logic [N-1:0]      match;
  logic [N-1:0]      row_we;
  logic [VPN_W-1:0]  vpn_q   [N];
  logic [ASID_W-1:0] asid_q  [N];
  logic [PFN_W-1:0]  pfn_q   [N];
  perm_t             kperm_q [N];
  perm_t             uperm_q [N];

  for (genvar g = 0; g < N; g++) begin : g_row
    assign row_we[g] = wr_en_i && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (row_we[g]) begin
        vpn_q[g]   <= wr_vpn_i;
        asid_q[g]  <= wr_asid_i;
        pfn_q[g]   <= wr_pfn_i;
        kperm_q[g] <= wr_kperm_i;
        uperm_q[g] <= wr_uperm_i;
      end
    end

    assign match[g] = valid_q[g] && (vpn_q[g] == look_vpn_i) &&
                      (asid_q[g] == look_asid_i);
  end

  // Invalidate wins over a simultaneous write
  always_comb begin
    if (clear_i) valid_d = '0;
    else         valid_d = valid_q | row_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  valid_q <= '0;
    else if (clear_i || wr_en_i) valid_q <= valid_d;
  end

  // One-hot read mux
  always_comb begin
    hit_idx_o   = '0;
    hit_pfn_o   = '0;
    hit_kperm_o = '0;
    hit_uperm_o = '0;
    for (int j = 0; j < N; j++) begin
      if (match[j]) begin
        hit_idx_o   = hit_idx_o | IDX_W'(j);
        hit_pfn_o   = hit_pfn_o | pfn_q[j];
        hit_kperm_o = hit_kperm_o | kperm_q[j];
        hit_uperm_o = hit_uperm_o | uperm_q[j];
      end
    end
  end

  assign hit_o   = |match;
  assign valid_o = valid_q;

  AST_MATCH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));  // R1
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (valid_q == '0));  // R9
  AST_WRITE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !clear_i) |=> valid_q[$past(wr_idx_i)]);  // R5
  AST_WRITE_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !clear_i) |=> $countones(valid_q) >= $countones($past(valid_q)));  // R8

endmodule

// File: rtl/utlb_plru.sv
module utlb_plru #(
  parameter int N      = 8,
  localparam int IDX_W = $clog2(N),
  localparam int NODES = N - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  output logic [IDX_W-1:0] victim_o
);

  logic [NODES-1:0] tree_q;
  logic [NODES-1:0] tree_d;

  // Walk from the root following the stored direction bits
  always_comb begin
    int node;
    node = 0;
    for (int l = 0; l < IDX_W; l++) begin
      node = 2 * node + 1 + int'(tree_q[node]);
    end
    victim_o = IDX_W'(node - NODES);
  end

  // Point every node on the accessed path away from it
  always_comb begin
    int node;
    logic dir;
    tree_d = tree_q;
    node   = 0;
    for (int l = 0; l < IDX_W; l++) begin
      dir          = touch_idx_i[IDX_W-1-l];
      tree_d[node] = ~dir;
      node         = 2 * node + 1 + int'(dir);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tree_q <= '0;
    else if (touch_i) tree_q <= tree_d;
  end

  AST_TOUCH_NOT_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
    touch_i |=> (victim_o != $past(touch_idx_i)));  // R7

endmodule

// File: rtl/utlb_refill_ctl.sv
module utlb_refill_ctl
  import utlb_pkg::*;
#(
  parameter int VPN_W  = 19,
  parameter int ASID_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              done_i,
  input  logic              cancel_i,
  input  logic [VPN_W-1:0]  vpn_i,
  input  logic [ASID_W-1:0] asid_i,
  output logic              busy_o,
  output logic [VPN_W-1:0]  vpn_o,
  output logic [ASID_W-1:0] asid_o
);

  rf_state_e         state_q;
  rf_state_e         state_d;
  logic              cap_en;
  logic [VPN_W-1:0]  vpn_q;
  logic [ASID_W-1:0] asid_q;

  always_comb begin
    state_d = state_q;
    cap_en  = 1'b0;
    unique case (state_q)
      RF_IDLE: begin
        if (start_i && !cancel_i) begin
          state_d = RF_WAIT;
          cap_en  = 1'b1;
        end
      end
      RF_WAIT: begin
        if (cancel_i || done_i) state_d = RF_IDLE;
      end
      default: state_d = RF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RF_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpn_q  <= '0;
      asid_q <= '0;
    end else if (cap_en) begin
      vpn_q  <= vpn_i;
      asid_q <= asid_i;
    end
  end

  assign busy_o = (state_q == RF_WAIT);
  assign vpn_o  = vpn_q;
  assign asid_o = asid_q;

  AST_CANCEL_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_i |=> !busy_o);  // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_i && !cancel_i) |=> (busy_o && $stable(vpn_o) && $stable(asid_o)));  // R3
  AST_DONE_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && done_i) |=> !busy_o);  // R5

endmodule

// File: rtl/utlb_top.sv
module utlb_top
  import utlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 19,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 19,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic [2:0]        lk_kperm,
  output logic [2:0]        lk_uperm,
  output logic              rf_req,
  output logic [VPN_W-1:0]  rf_vpn,
  output logic [ASID_W-1:0] rf_asid,
  input  logic              rf_valid,
  input  logic [PFN_W-1:0]  rf_pfn,
  input  logic [2:0]        rf_kperm,
  input  logic [2:0]        rf_uperm,
  input  logic              inv_all
);

  logic               tag_hit;
  logic [IDX_W-1:0]   hit_idx;
  logic [ENTRIES-1:0] valid;
  logic [IDX_W-1:0]   plru_victim;
  logic [IDX_W-1:0]   free_idx;
  logic               any_free;
  logic [IDX_W-1:0]   fill_idx;
  logic               fill_we;
  logic               miss_start;
  logic               touch;
  logic [IDX_W-1:0]   touch_idx;
  perm_t              hit_kperm;
  perm_t              hit_uperm;

  utlb_cam #(
    .N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)
  ) cam_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (inv_all),
    .wr_en_i     (fill_we),
    .wr_idx_i    (fill_idx),
    .wr_vpn_i    (rf_vpn),
    .wr_asid_i   (rf_asid),
    .wr_pfn_i    (rf_pfn),
    .wr_kperm_i  (rf_kperm),
    .wr_uperm_i  (rf_uperm),
    .look_vpn_i  (lk_vpn),
    .look_asid_i (lk_asid),
    .hit_o       (tag_hit),
    .hit_idx_o   (hit_idx),
    .hit_pfn_o   (lk_pfn),
    .hit_kperm_o (hit_kperm),
    .hit_uperm_o (hit_uperm),
    .valid_o     (valid)
  );

  utlb_plru #(.N(ENTRIES)) plru_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .touch_i     (touch),
    .touch_idx_i (touch_idx),
    .victim_o    (plru_victim)
  );

  utlb_refill_ctl #(.VPN_W(VPN_W), .ASID_W(ASID_W)) rfc_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (miss_start),
    .done_i   (rf_valid),
    .cancel_i (inv_all),
    .vpn_i    (lk_vpn),
    .asid_i   (lk_asid),
    .busy_o   (rf_req),
    .vpn_o    (rf_vpn),
    .asid_o   (rf_asid)
  );

  // Lowest-numbered free slot first
  always_comb begin
    free_idx = '0;
    for (int j = ENTRIES - 1; j >= 0; j--) begin
      if (!valid[j]) free_idx = IDX_W'(j);
    end
  end

  assign any_free = ~&valid;
  assign fill_idx = any_free ? free_idx : plru_victim;

  // Lookups stall behind a pending refill
  assign lk_hit     = lk_valid && !rf_req && tag_hit;
  assign lk_miss    = lk_valid && !lk_hit;
  assign miss_start = lk_miss && !rf_req;
  assign fill_we    = rf_req && rf_valid && !inv_all;

  assign lk_kperm = hit_kperm;
  assign lk_uperm = hit_uperm;

  assign touch     = lk_hit || fill_we;
  assign touch_idx = fill_we ? fill_idx : hit_idx;

  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss));  // R1
  AST_STALL_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_req && lk_valid) |-> lk_miss);  // R4
  AST_FILL_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_we && any_free) |-> !valid[fill_idx]);  // R6
  AST_INV_FILL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_all && rf_valid) |=> (valid == '0));  // R10

endmodule

// File: tb/utlb_top_tb_top.sv
module utlb_top_tb_top;

  localparam int NE = 8;
  localparam int VW = 19;
  localparam int AW = 8;
  localparam int PW = 19;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lk_valid = 1'b0;
  logic [VW-1:0] lk_vpn = '0;
  logic [AW-1:0] lk_asid = '0;
  logic          lk_hit, lk_miss, rf_req;
  logic [PW-1:0] lk_pfn;
  logic [2:0]    lk_kperm, lk_uperm;
  logic [VW-1:0] rf_vpn;
  logic [AW-1:0] rf_asid;
  logic          rf_valid = 1'b0;
  logic [PW-1:0] rf_pfn = '0;
  logic [2:0]    rf_kperm = '0;
  logic [2:0]    rf_uperm = '0;
  logic          inv_all = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Bench model
  logic          m_val  [NE];
  logic [VW-1:0] m_vpn  [NE];
  logic [AW-1:0] m_asid [NE];
  logic [NE-2:0] m_tree;

  always #2 clk = ~clk;

  utlb_top dut_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn),
    .lk_asid(lk_asid), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pfn(lk_pfn),
    .lk_kperm(lk_kperm), .lk_uperm(lk_uperm), .rf_req(rf_req),
    .rf_vpn(rf_vpn), .rf_asid(rf_asid), .rf_valid(rf_valid),
    .rf_pfn(rf_pfn), .rf_kperm(rf_kperm), .rf_uperm(rf_uperm),
    .inv_all(inv_all)
  );

  function automatic logic [PW-1:0] exp_pfn(logic [VW-1:0] v, logic [AW-1:0] a);
    return PW'(v * 13 + a * 1000 + 5);
  endfunction
  function automatic logic [2:0] exp_kp(logic [VW-1:0] v);
    return v[2:0];
  endfunction
  function automatic logic [2:0] exp_up(logic [VW-1:0] v, logic [AW-1:0] a);
    return 3'(v + VW'(a));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int m_find(logic [VW-1:0] v, logic [AW-1:0] a);
    for (int j = 0; j < NE; j++)
      if (m_val[j] && m_vpn[j] == v && m_asid[j] == a) return j;
    return -1;
  endfunction

  function automatic int m_victim();
    int node;
    for (int j = 0; j < NE; j++) if (!m_val[j]) return j;
    node = 0;
    for (int l = 0; l < 3; l++) node = 2 * node + 1 + int'(m_tree[node]);
    return node - (NE - 1);
  endfunction

  task automatic m_touch(input int w);
    int node;
    int dir;
    node = 0;
    for (int l = 0; l < 3; l++) begin
      dir = (w >> (2 - l)) & 1;
      m_tree[node] = (dir == 0);
      node = 2 * node + 1 + dir;
    end
  endtask

  task automatic m_clear();
    for (int j = 0; j < NE; j++) m_val[j] = 1'b0;
  endtask

  // One lookup; on a miss the refill is served after 'stall' probe cycles
  task automatic access(input logic [VW-1:0] v, input logic [AW-1:0] a,
                        input int stall, input string tag);
    int k;
    int w;
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = v; lk_asid = a;
    #1;
    k = m_find(v, a);
    if (k >= 0) begin
      chk(lk_hit === 1'b1 && lk_miss === 1'b0, tag, {30'd0, lk_hit, lk_miss}, 32'h2);
      chk(lk_pfn === exp_pfn(v, a), tag, 32'(lk_pfn), 32'(exp_pfn(v, a)));
      chk(lk_kperm === exp_kp(v) && lk_uperm === exp_up(v, a), tag,
          {26'd0, lk_kperm, lk_uperm}, {26'd0, exp_kp(v), exp_up(v, a)});
      @(posedge clk);
      m_touch(k);
    end else begin
      chk(lk_miss === 1'b1 && lk_hit === 1'b0, tag, {30'd0, lk_hit, lk_miss}, 32'h1);
      @(posedge clk);
      @(negedge clk);
      lk_valid = 1'b0;
      #1;
      chk(rf_req === 1'b1, "R3 request", {31'd0, rf_req}, 32'd1);
      chk(rf_vpn === v && rf_asid === a, "R3 tag", 32'(rf_vpn), 32'(v));
      for (int s = 0; s < stall; s++) begin
        lk_valid = 1'b1;
        if (m_val[s % NE]) begin
          lk_vpn = m_vpn[s % NE]; lk_asid = m_asid[s % NE];
        end else begin
          lk_vpn = v; lk_asid = a;
        end
        #0.5;
        chk(lk_miss === 1'b1 && lk_hit === 1'b0, "R4 stall", {30'd0, lk_hit, lk_miss}, 32'h1);
        @(negedge clk);
        lk_valid = 1'b0;
        #1;
        chk(rf_req === 1'b1 && rf_vpn === v && rf_asid === a, "R4 tag held",
            32'(rf_vpn), 32'(v));
      end
      rf_valid = 1'b1; rf_pfn = exp_pfn(v, a);
      rf_kperm = exp_kp(v); rf_uperm = exp_up(v, a);
      @(posedge clk);
      w = m_victim();
      m_val[w] = 1'b1; m_vpn[w] = v; m_asid[w] = a;
      m_touch(w);
      @(negedge clk);
      rf_valid = 1'b0;
      #1;
      chk(rf_req === 1'b0, "R5 request drop", {31'd0, rf_req}, 32'd0);
    end
  endtask

  task automatic pulse_inv();
    @(negedge clk);
    lk_valid = 1'b0; inv_all = 1'b1;
    @(posedge clk);
    m_clear();
    @(negedge clk);
    inv_all = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned s;
    m_clear();
    m_tree = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    lk_valid = 1'b1; lk_vpn = 19'd3; lk_asid = 8'd1;
    #1;
    chk(lk_hit === 1'b0 && lk_miss === 1'b1, "R11 lookup", {30'd0, lk_hit, lk_miss}, 32'h1);
    chk(rf_req === 1'b0, "R11 request", {31'd0, rf_req}, 32'd0);
    @(negedge clk);
    lk_valid = 1'b0;
    @(negedge clk);
    // One cycle of miss started a refill; cancel it
    pulse_inv();

    // R5: refill data with nothing pending is ignored
    @(negedge clk);
    rf_valid = 1'b1; rf_pfn = 19'h1234;
    @(negedge clk);
    rf_valid = 1'b0;
    access(19'd3, 8'd1, 1, "R5 stray refill");

    // R6: fill empty slots, with hits in between
    access(19'd4, 8'd1, 0, "R6");
    access(19'd3, 8'd1, 0, "R1");
    access(19'd5, 8'd1, 2, "R6");
    access(19'd3, 8'd1, 0, "R1");
    for (int i = 6; i < 11; i++) access(19'(i), 8'd1, 1, "R6");
    for (int i = 3; i < 11; i++) access(19'(i), 8'd1, 0, "R6");

    // R2: same page, other identifier
    access(19'd4, 8'd2, 1, "R2");
    // R8: the other entries survive a fill
    for (int i = 3; i < 11; i++) access(19'(i), 8'd1, 0, "R8");

    // R7: pseudo-random sweep over 24 tags
    s = 32'd7;
    for (int n = 0; n < 400; n++) begin
      s = s * 32'd1103515245 + 32'd12345;
      access(19'((s >> 16) % 12), 8'(((s >> 8) % 2) + 1), int'((s >> 4) % 3), "R7");
    end

    // R9: invalidate clears everything
    pulse_inv();
    access(19'd4, 8'd1, 0, "R9 after inv");
    // R9: invalidate cancels a pending refill
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = 19'd20; lk_asid = 8'd1;
    @(negedge clk);
    lk_valid = 1'b0;
    #1;
    chk(rf_req === 1'b1, "R9 pending", {31'd0, rf_req}, 32'd1);
    pulse_inv();
    #1;
    chk(rf_req === 1'b0, "R9 cancel", {31'd0, rf_req}, 32'd0);
    access(19'd4, 8'd1, 0, "R9 entry gone");
    // R9: miss together with invalidate starts nothing
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = 19'd21; lk_asid = 8'd1; inv_all = 1'b1;
    @(posedge clk);
    m_clear();
    @(negedge clk);
    lk_valid = 1'b0; inv_all = 1'b0;
    #1;
    chk(rf_req === 1'b0, "R9 no start", {31'd0, rf_req}, 32'd0);

    // R10: invalidate with refill data
    access(19'd6, 8'd2, 0, "R10 setup");
    @(negedge clk);
    lk_valid = 1'b1; lk_vpn = 19'd22; lk_asid = 8'd2;
    @(negedge clk);
    lk_valid = 1'b0;
    rf_valid = 1'b1; inv_all = 1'b1;
    rf_pfn = exp_pfn(19'd22, 8'd2); rf_kperm = 3'd6; rf_uperm = 3'd0;
    @(posedge clk);
    m_clear();
    @(negedge clk);
    rf_valid = 1'b0; inv_all = 1'b0;
    #1;
    chk(rf_req === 1'b0, "R10 request", {31'd0, rf_req}, 32'd0);
    access(19'd22, 8'd2, 0, "R10 not valid");
    access(19'd6, 8'd2, 0, "R10 others cleared");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule